// File: doc/BRIEF.md
# Horizontal Character-Clock Line Timer

This block counts character clocks across one horizontal scan line of a CRT timing controller. The count starts at zero, rises by one on every character clock, and returns to zero after it reaches the line length. From the count the block derives three things. The first is a display-enable window, which is high from the start of the line up to a visible limit. The second is a horizontal sync pulse, which starts at a programmable position. The third is an end-of-line strobe.

Software can write a new line length (total), displayed count or sync position at any time, including partway through a line. Each write is judged against the live count. A total that the counter has already passed forces the current line to run to the maximum count, because the counter must wrap round. A displayed count that the counter has already reached opens the border for the rest of the line. A sync position that arrives after the sync has already started waits for the next line. At every line end the stored values are loaded again, so the next line runs with the programmed settings.

Top module: `hline_timer`

## Requirements
- R1: `count` rises by one on each clock and returns to 0 on the clock after a cycle where `count` equals the line length. `eol` is high in exactly that cycle.
- R2: After reset, `count` is 0, `eol` and `hsync` are low, and `disp_en` is high. Total, displayed count and sync position take the parameter defaults DEF_TOTAL, DEF_DISP and DEF_SYNC.
- R3: A total write whose value is below the current count, in a cycle that is not end of line, sets the current line length to the maximum count (2^CW-1). The next line uses the written value.
- R4: A total write whose value is not below the current count sets the length of the current line to that value.
- R5: A displayed-count write made while the count is below the visible limit, with a value greater than the count, moves the visible limit of the current line to that value.
- R6: A displayed-count write made while the count is below the visible limit, with a value not greater than the count, drops `disp_en` for the rest of the line. The next line uses the written value.
- R7: A displayed-count write made once the count has reached the visible limit leaves the current line unchanged and takes effect from the next line.
- R8: A sync-position write takes effect in the current line only if the count is still below the present sync position. Otherwise it takes effect from the next line.
- R9: `hsync` rises in the cycle where `count` equals the sync position and stays high for `sync_width` clocks. The pulse may run past the line end. A width of 0 gives no pulse.
- R10: `disp_en` is high exactly when the count is below the visible limit and the display has not been switched off in the current line. At each line start the limit is reloaded and the display is switched on again.
- R11: Any write made in an end-of-line cycle applies in full to the next line, starting from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| total_we | input | 1 | Write strobe for the line total |
| total_val | input | CW | New total (last count of the line) |
| disp_we | input | 1 | Write strobe for the displayed count |
| disp_val | input | CW | New displayed count |
| sync_we | input | 1 | Write strobe for the sync position |
| sync_val | input | CW | New sync position |
| sync_width | input | SWW | Sync pulse length in clocks |
| count | output | CW | Current character count |
| disp_en | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| eol | output | 1 | End-of-line strobe |

## Verification
The bench uses CW=8, so a line stretched by a late total write really runs to count 255 and wraps. This checks the full maximum-length path. The defaults are cut to a total of 15, displayed count 10 and sync position 12. Short lines let every mid-line write rule be tried before, at and after each limit within a few hundred cycles. SWW=4 allows sync widths long enough to cross the line end.

// File: rtl/hline_pkg.sv
package hline_pkg;

    typedef enum logic {
        SYNC_IDLE = 1'b0,
        SYNC_BUSY = 1'b1
    } sync_phase_e;

    typedef enum logic [1:0] {
        WIN_KEEP   = 2'd0,
        WIN_MOVE   = 2'd1,
        WIN_CLOSE  = 2'd2,
        WIN_RELOAD = 2'd3
    } win_action_e;

    // Decide what a displayed-count write does to the live window.
    function automatic win_action_e win_decide(
        input logic at_end,
        input logic wr,
        input logic still_visible,
        input logic above_count
    );
        if (at_end)
            return WIN_RELOAD;
        if (!wr || !still_visible)
            return WIN_KEEP;
        return above_count ? WIN_MOVE : WIN_CLOSE;
    endfunction

endpackage

// File: rtl/hline_count.sv
module hline_count #(
    parameter int CW        = 8,
    parameter int DEF_TOTAL = 63
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          total_we,
    input  logic [CW-1:0] total_val,
    output logic [CW-1:0] count,
    output logic [CW-1:0] line_len,
    output logic          eol
);
    localparam logic [CW-1:0] MAX_CNT = {CW{1'b1}};
    localparam logic [CW-1:0] RST_TOT = CW'(DEF_TOTAL);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] tot_q;

    assign eol = (cnt_q == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= RST_TOT;
            tot_q <= RST_TOT;
        end else begin
            cnt_q <= eol ? '0 : cnt_q + 1'b1;
            if (total_we) begin
                tot_q <= total_val;
                if (!eol && (cnt_q > total_val))
                    len_q <= MAX_CNT;
                else
                    len_q <= total_val;
            end else if (eol) begin
                len_q <= tot_q;
            end
        end
    end

    assign count    = cnt_q;
    assign line_len = len_q;
endmodule

// File: rtl/hline_window.sv
module hline_window
    import hline_pkg::*;
#(
    parameter int CW       = 8,
    parameter int DEF_DISP = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] line_len,
    input  logic          eol,
    input  logic          disp_we,
    input  logic [CW-1:0] disp_val,
    output logic          disp_en
);
    localparam logic [CW-1:0] RST_DISP = CW'(DEF_DISP);

    logic [CW:0]   vis_q;
    logic          hen_q;
    logic [CW-1:0] dreg_q;
    logic          still_vis;
    win_action_e   act;

    assign still_vis = ({1'b0, count} < vis_q);
    assign act       = win_decide(eol, disp_we, still_vis, disp_val > count);

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q  <= {1'b0, RST_DISP};
            hen_q  <= 1'b1;
            dreg_q <= RST_DISP;
        end else begin
            if (disp_we)
                dreg_q <= disp_val;
            case (act)
                WIN_RELOAD: begin
                    vis_q <= {1'b0, (disp_we ? disp_val : dreg_q)};
                    hen_q <= 1'b1;
                end
                WIN_MOVE: begin
                    vis_q <= {1'b0, disp_val};
                    hen_q <= 1'b1;
                end
                WIN_CLOSE: begin
                    vis_q <= {1'b0, line_len} + 1'b1;
                    hen_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign disp_en = hen_q && still_vis;
endmodule

// File: rtl/hline_sync.sv
module hline_sync
    import hline_pkg::*;
#(
    parameter int CW       = 8,
    parameter int SWW      = 4,
    parameter int DEF_SYNC = 50
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  count,
    input  logic           eol,
    input  logic           sync_we,
    input  logic [CW-1:0]  sync_val,
    input  logic [SWW-1:0] sync_width,
    output logic           hsync
);
    localparam logic [CW-1:0] RST_SYNC = CW'(DEF_SYNC);

    logic [CW-1:0]  pos_q;
    logic [CW-1:0]  sreg_q;
    logic [SWW-1:0] left_q;
    logic           start;
    sync_phase_e    phase;

    assign start = (count == pos_q) && (sync_width != '0);
    assign phase = (left_q != '0) ? SYNC_BUSY : SYNC_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= RST_SYNC;
            sreg_q <= RST_SYNC;
        end else begin
            if (sync_we)
                sreg_q <= sync_val;
            if (eol)
                pos_q <= sync_we ? sync_val : sreg_q;
            else if (sync_we && (count < pos_q))
                pos_q <= sync_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (start)
            left_q <= sync_width - 1'b1;
        else if (phase == SYNC_BUSY)
            left_q <= left_q - 1'b1;
    end

    assign hsync = start || (phase == SYNC_BUSY);
endmodule

// File: rtl/hline_timer.sv
module hline_timer #(
    parameter int CW        = 8,
    parameter int SWW       = 4,
    parameter int DEF_TOTAL = 63,
    parameter int DEF_DISP  = 40,
    parameter int DEF_SYNC  = 50
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           total_we,
    input  logic [CW-1:0]  total_val,
    input  logic           disp_we,
    input  logic [CW-1:0]  disp_val,
    input  logic           sync_we,
    input  logic [CW-1:0]  sync_val,
    input  logic [SWW-1:0] sync_width,
    output logic [CW-1:0]  count,
    output logic           disp_en,
    output logic           hsync,
    output logic           eol
);
    logic [CW-1:0] line_len;

    hline_count #(.CW(CW), .DEF_TOTAL(DEF_TOTAL)) u_count (
        .clk(clk), .rst(rst),
        .total_we(total_we), .total_val(total_val),
        .count(count), .line_len(line_len), .eol(eol)
    );

    hline_window #(.CW(CW), .DEF_DISP(DEF_DISP)) u_window (
        .clk(clk), .rst(rst),
        .count(count), .line_len(line_len), .eol(eol),
        .disp_we(disp_we), .disp_val(disp_val),
        .disp_en(disp_en)
    );

    hline_sync #(.CW(CW), .SWW(SWW), .DEF_SYNC(DEF_SYNC)) u_sync (
        .clk(clk), .rst(rst),
        .count(count), .eol(eol),
        .sync_we(sync_we), .sync_val(sync_val), .sync_width(sync_width),
        .hsync(hsync)
    );
endmodule

// File: rtl/hline_timer_chk.sv
module hline_timer_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          total_we,
    input logic [CW-1:0] total_val,
    input logic          disp_we,
    input logic [CW-1:0] count,
    input logic          disp_en,
    input logic          eol
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !eol |=> count == $past(count) + 1'b1); // R1

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        eol |=> count == '0); // R1

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (count == '0) && !eol); // R2

    AST_LATE_TOTAL_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (total_we && !eol && (total_val < count)) |=> !eol); // R3

    AST_BORDER_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (!disp_en && !eol && !disp_we) |=> !disp_en); // R10
endmodule

bind hline_timer hline_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .total_we(total_we), .total_val(total_val),
    .disp_we(disp_we), .count(count), .disp_en(disp_en), .eol(eol)
);

// File: tb/hline_timer_tb.sv
module hline_timer_tb;
    localparam int CW = 8;
    localparam int SWW = 4;
    localparam int D_TOT = 15;
    localparam int D_DISP = 10;
    localparam int D_SYNC = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic total_we = 0, disp_we = 0, sync_we = 0;
    logic [CW-1:0] total_val = '0, disp_val = '0, sync_val = '0;
    logic [SWW-1:0] sync_width = 4'd3;
    logic [CW-1:0] count;
    logic disp_en, hsync, eol;

    int checks = 0;
    int fails = 0;
    string tag = "R2";

    always #10 clk = ~clk;

    hline_timer #(.CW(CW), .SWW(SWW), .DEF_TOTAL(D_TOT),
                  .DEF_DISP(D_DISP), .DEF_SYNC(D_SYNC)) u_dut (
        .clk(clk), .rst(rst), .total_we(total_we), .total_val(total_val),
        .disp_we(disp_we), .disp_val(disp_val), .sync_we(sync_we),
        .sync_val(sync_val), .sync_width(sync_width),
        .count(count), .disp_en(disp_en), .hsync(hsync), .eol(eol)
    );

    // Behavioural reference model
    int m_cnt, m_len, m_tot, m_lim, m_dreg, m_pos, m_sreg, m_left;
    bit m_on;

    function automatic bit m_eol();
        return m_cnt == m_len;
    endfunction
    function automatic bit m_disp();
        return m_on && (m_cnt < m_lim);
    endfunction
    function automatic bit m_start();
        return (m_cnt == m_pos) && (sync_width != 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_len = D_TOT; m_tot = D_TOT;
            m_lim = D_DISP; m_dreg = D_DISP; m_on = 1;
            m_pos = D_SYNC; m_sreg = D_SYNC; m_left = 0;
        end else begin
            automatic bit e = m_eol();
            automatic bit st = m_start();
            automatic int c = m_cnt;
            automatic int len_old = m_len;
            // sync pulse length
            if (st) m_left = int'(sync_width) - 1;
            else if (m_left > 0) m_left--;
            // sync position
            if (sync_we) m_sreg = sync_val;
            if (e) m_pos = m_sreg;
            else if (sync_we && c < m_pos) m_pos = sync_val;
            // display window
            if (disp_we) m_dreg = disp_val;
            if (e) begin m_lim = m_dreg; m_on = 1; end
            else if (disp_we && c < m_lim) begin
                if (disp_val > c) begin m_lim = disp_val; m_on = 1; end
                else begin m_lim = len_old + 1; m_on = 0; end
            end
            // total
            if (total_we) begin
                m_tot = total_val;
                m_len = (!e && c > total_val) ? 255 : total_val;
            end else if (e) m_len = m_tot;
            m_cnt = e ? 0 : c + 1;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d @%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("count", count, m_cnt);
            chk("eol", eol, m_eol());
            chk("disp_en", disp_en, m_disp());
            chk("hsync", hsync, m_start() || (m_left > 0));
        end
    end

    task automatic wait_cnt(input int k);
        do @(negedge clk); while (count != k);
        #1;
    endtask

    task automatic wait_eol();
        do @(negedge clk); while (!eol);
        #1;
    endtask

    task automatic pulse();
        @(negedge clk); #1;
        total_we = 0; disp_we = 0; sync_we = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        tag = "R2";
        chk("reset count", count, 1);
        run(40);
        tag = "R1";
        wait_eol();
        chk("eol at total", count, D_TOT);
        run(20);

        tag = "R4"; wait_cnt(3);
        total_we = 1; total_val = 20; pulse();
        run(50);

        tag = "R3"; wait_cnt(8);
        total_we = 1; total_val = 5; pulse();
        wait_cnt(200);
        chk("stretched line count", count, 200);
        run(80);
        wait_eol();
        chk("next line short end", count, 5);
        total_we = 1; total_val = 15; pulse();
        run(20);

        tag = "R5"; wait_cnt(2);
        disp_we = 1; disp_val = 6; pulse();
        run(20);

        tag = "R6"; wait_cnt(4);
        disp_we = 1; disp_val = 3; pulse();
        chk("border open", disp_en, 0);
        run(30);

        tag = "R7"; wait_cnt(12);
        disp_we = 1; disp_val = 9; pulse();
        run(34);

        tag = "R8"; wait_cnt(4);
        sync_we = 1; sync_val = 7; pulse();
        run(8);
        wait_cnt(10);
        sync_we = 1; sync_val = 2; pulse();
        run(34);

        tag = "R9";
        sync_width = 0; run(34);
        sync_width = 1; run(34);
        sync_width = 15; run(34);
        wait_cnt(1);
        sync_width = 6;
        sync_we = 1; sync_val = 13; pulse();
        run(40);

        tag = "R10"; wait_cnt(1);
        disp_we = 1; disp_val = 14; pulse();
        run(20);

        tag = "R11"; wait_eol();
        total_we = 1; total_val = 9; disp_we = 1; disp_val = 4;
        sync_we = 1; sync_val = 6; pulse();
        chk("line restart", count, 0);
        run(40);
        wait_eol();
        chk("new total used", count, 9);
        run(5);

        finish_run();
    end
endmodule